// File: doc/BRIEF.md
# Track Protect and Status Word

This block sits beside the data path of a head-per-track storage interface, in front of either a fixed-head disk or a drum. It builds the 16-bit word that the host reads back as status, and it decides whether the data path may drive write current for the track named in the current command. Protection is coarse. A front-panel switch turns it on, and a code picks how many tracks, counted from track zero, become read-only. A write aimed at a protected track is not refused. The transfer runs with normal timing and flags, but the data path sees the write qualifier low and stores nothing. No error bit reports this. Software is expected to look at the write-enabled bit before it starts the write.

The block keeps three sticky condition bits: sector coincidence, abort and parity. A new transfer clears them. It also runs a short read-inhibit window in disk mode, which opens each time a command word is written and lasts 64 word ticks. All other status fields pass straight through from the unit, and the unit's fields are shown only while a medium is attached.

Top module: `fhs_status_unit`

## Requirements
- R1: `wr_enable` is 1 when `prot_switch` is 0, or when the effective track number is greater than or equal to the protected-track count. Status bit 2 always equals `wr_enable`, whether or not a medium is attached.
- R2: `prot_code` selects the protected-track count as follows. Codes 0 to 7 give 1, 2, 4, 8, 16, 32, 64 and 128 tracks. In drum mode, codes 8, 9 and 10 give 256, 512 and 768 tracks, and any code above 10 gives 768. In disk mode, any code above 7 gives 128.
- R3: In disk mode (`drum_mode` = 0), only the low 7 bits of `cmd_track` form the track number. In drum mode, all bits of `cmd_track` are used.
- R4: The status bits are laid out as follows:
  - bit 15: sector flag
  - bits 14:8: next sector
  - bit 7: ready
  - bit 6: read inhibit
  - bit 5: sector coincidence
  - bit 4: always 0
  - bit 3: abort
  - bit 2: write enabled
  - bit 1: parity error
  - bit 0: busy
- R5: When `attached` is 0, status bits 15:6 and bit 0 read as 0. When `attached` is 1:
  - bit 15 follows `sector_phase`;
  - bits 14:8 follow `next_sector`;
  - bit 7 is 1;
  - bit 0 follows `busy`.
- R6: In disk mode, a cycle with `cw_strobe` high (re)starts a window of 64 `word_tick` pulses. The window is open from the next cycle until the 64th tick after the strobe, and a strobe in the same cycle as a tick takes precedence over the tick. Status bit 6 is 1 only while the window is open, `cmd_write` is 0 and `attached` is 1. In drum mode, `cw_strobe` does not open or restart the window.
- R7: The sticky bits are set as follows:
  - `coinc_set` sets bit 5;
  - `abort_set` sets bit 3;
  - `write_done` sets bit 1 only in disk mode; in drum mode `write_done` leaves bit 1 unchanged.
- R8: `xfer_start` clears bits 5, 3 and 1. A set input active in the same cycle wins for its own bit.
- R9: Synchronous active-high `rst` clears the sticky bits and closes the read-inhibit window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| drum_mode | input | 1 | 0 = disk mode, 1 = drum mode |
| cmd_write | input | 1 | Write bit of the current command word |
| cmd_track | input | TRK_W | Track field of the current command word |
| prot_switch | input | 1 | Track protect switch on |
| prot_code | input | 4 | Protected-track count code |
| attached | input | 1 | Medium attached / unit ready |
| busy | input | 1 | Transfer in progress |
| next_sector | input | 7 | Sector counter value |
| sector_phase | input | 1 | Sector clock phase flag |
| cw_strobe | input | 1 | Command word written this cycle |
| word_tick | input | 1 | One word time elapsed |
| xfer_start | input | 1 | A new transfer starts |
| coinc_set | input | 1 | Sector coincidence reached |
| abort_set | input | 1 | Transfer aborted |
| write_done | input | 1 | A write operation finished |
| status | output | 16 | Assembled status word |
| wr_enable | output | 1 | Write qualifier for the data path |

## Verification
The hardest condition to reach from the ports is the exact edge of the read-inhibit window. The stimulus writes a command word and then holds `word_tick` high for exactly 63 cycles, where bit 6 must still be set. One more tick must clear it. A second run restarts the window partway through, to show that a new strobe reloads the full count. The disk-mode masking of the track number is reached by giving tracks whose bit 7 is set, so that the masked number falls on the other side of the protection limit.

// File: rtl/fhs_pkg.sv
package fhs_pkg;

    localparam int SEC_W   = 7;
    localparam int LIMIT_W = 11;

    typedef enum logic {
        MODE_DISK = 1'b0,
        MODE_DRUM = 1'b1
    } fhs_mode_e;

    typedef struct packed {
        logic             sector_flag;
        logic [SEC_W-1:0] next_sec;
        logic             ready;
        logic             rd_inhibit;
        logic             coinc;
        logic             spare;
        logic             abort_f;
        logic             wr_en;
        logic             parity;
        logic             busy;
    } fhs_status_t;

    typedef struct packed {
        logic coinc;
        logic abort_f;
        logic parity;
    } fhs_sticky_t;

    // Protected-track count for a selection code; the allowed set depends on mode.
    function automatic logic [LIMIT_W-1:0] prot_limit(fhs_mode_e mode, logic [3:0] code);
        logic [LIMIT_W-1:0] lim;
        if (code <= 4'd7)
            lim = LIMIT_W'(1) << code;
        else if (mode == MODE_DISK)
            lim = LIMIT_W'(128);
        else if (code == 4'd8)
            lim = LIMIT_W'(256);
        else if (code == 4'd9)
            lim = LIMIT_W'(512);
        else
            lim = LIMIT_W'(768);
        return lim;
    endfunction

endpackage

// File: rtl/fhs_protect.sv
module fhs_protect
    import fhs_pkg::*;
#(
    parameter int TRK_W      = 10,
    parameter int DISK_TRK_W = 7
) (
    input  fhs_mode_e        mode,
    input  logic             prot_switch,
    input  logic [3:0]       prot_code,
    input  logic [TRK_W-1:0] track,
    output logic             wr_enable
);
    localparam int CMP_W = (TRK_W > LIMIT_W) ? TRK_W : LIMIT_W;
    localparam logic [TRK_W-1:0] DISK_MASK = TRK_W'((1 << DISK_TRK_W) - 1);

    logic [TRK_W-1:0] trk_eff;
    logic [CMP_W-1:0] trk_cmp;
    logic [CMP_W-1:0] lim_cmp;

    always_comb begin
        trk_eff   = (mode == MODE_DISK) ? (track & DISK_MASK) : track;
        trk_cmp   = CMP_W'(trk_eff);
        lim_cmp   = CMP_W'(prot_limit(mode, prot_code));
        wr_enable = !prot_switch || (trk_cmp >= lim_cmp);
    end

    // R1: an unprotected unit always allows writes
    always_comb begin
        p_unprot_r1: assert (prot_switch || wr_enable);
    end

endmodule

// File: rtl/fhs_inhibit_timer.sv
module fhs_inhibit_timer #(
    parameter int TICKS = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic tick,
    output logic active
);
    localparam int CNT_W = $clog2(TICKS + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(TICKS);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (arm)
            remain <= LOAD;
        else if (tick && remain != '0)
            remain <= remain - 1'b1;
    end

    assign active = (remain != '0);

    // R6: a new command word reloads the full window
    p_reload_r6: assert property (@(posedge clk) disable iff (rst)
        arm |=> remain == LOAD);

    // R6: the window only drains on word ticks
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!arm && !tick) |=> $stable(remain));

    // R6: one tick removes exactly one unit from an open window
    p_drain_r6: assert property (@(posedge clk) disable iff (rst)
        (!arm && tick && remain != '0) |=> remain == $past(remain) - 1'b1);

endmodule

// File: rtl/fhs_sticky_flags.sv
module fhs_sticky_flags
    import fhs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  fhs_mode_e   mode,
    input  logic        clear,
    input  logic        set_coinc,
    input  logic        set_abort,
    input  logic        write_done,
    output fhs_sticky_t flags
);
    logic set_parity;
    assign set_parity = write_done && (mode == MODE_DISK);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            if (set_coinc)  flags.coinc   <= 1'b1;
            else if (clear) flags.coinc   <= 1'b0;
            if (set_abort)  flags.abort_f <= 1'b1;
            else if (clear) flags.abort_f <= 1'b0;
            if (set_parity) flags.parity  <= 1'b1;
            else if (clear) flags.parity  <= 1'b0;
        end
    end

    // R7: a finished disk write always leaves the parity bit up
    p_parity_r7: assert property (@(posedge clk) disable iff (rst)
        (write_done && mode == MODE_DISK) |=> flags.parity);

    // R7: in drum mode a clear parity bit stays clear
    p_drum_parity_r7: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_DRUM && !flags.parity) |=> !flags.parity);

    // R8: a new transfer drops coincidence unless it is set again
    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (clear && !set_coinc) |=> !flags.coinc);

endmodule

// File: rtl/fhs_status_unit.sv
module fhs_status_unit
    import fhs_pkg::*;
#(
    parameter int TRK_W         = 10,
    parameter int DISK_TRK_W    = 7,
    parameter int INHIBIT_TICKS = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             drum_mode,
    input  logic             cmd_write,
    input  logic [TRK_W-1:0] cmd_track,
    input  logic             prot_switch,
    input  logic [3:0]       prot_code,
    input  logic             attached,
    input  logic             busy,
    input  logic [SEC_W-1:0] next_sector,
    input  logic             sector_phase,
    input  logic             cw_strobe,
    input  logic             word_tick,
    input  logic             xfer_start,
    input  logic             coinc_set,
    input  logic             abort_set,
    input  logic             write_done,
    output logic [15:0]      status,
    output logic             wr_enable
);
    fhs_mode_e   mode;
    fhs_sticky_t sticky;
    fhs_status_t word;
    logic        window_open;
    logic        arm;

    assign mode = drum_mode ? MODE_DRUM : MODE_DISK;
    assign arm  = cw_strobe && (mode == MODE_DISK);

    fhs_protect #(
        .TRK_W      (TRK_W),
        .DISK_TRK_W (DISK_TRK_W)
    ) u_protect (
        .mode        (mode),
        .prot_switch (prot_switch),
        .prot_code   (prot_code),
        .track       (cmd_track),
        .wr_enable   (wr_enable)
    );

    fhs_inhibit_timer #(
        .TICKS (INHIBIT_TICKS)
    ) u_inhibit (
        .clk    (clk),
        .rst    (rst),
        .arm    (arm),
        .tick   (word_tick),
        .active (window_open)
    );

    fhs_sticky_flags u_sticky (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .clear      (xfer_start),
        .set_coinc  (coinc_set),
        .set_abort  (abort_set),
        .write_done (write_done),
        .flags      (sticky)
    );

    always_comb begin
        word             = '0;
        word.coinc       = sticky.coinc;
        word.abort_f     = sticky.abort_f;
        word.parity      = sticky.parity;
        word.wr_en       = wr_enable;
        if (attached) begin
            word.sector_flag = sector_phase;
            word.next_sec    = next_sector;
            word.ready       = 1'b1;
            word.busy        = busy;
            word.rd_inhibit  = window_open && !cmd_write;
        end
    end

    assign status = word;

    // R5: without a medium the dynamic fields are quiet
    p_detached_r5: assert property (@(posedge clk) disable iff (rst)
        !attached |-> (status[15:6] == 10'd0 && !status[0]));

    // R4: bit 4 is never driven
    p_spare_r4: assert property (@(posedge clk) disable iff (rst)
        !status[4]);

    // R6: a write command never reports read inhibit
    p_no_inhibit_write_r6: assert property (@(posedge clk) disable iff (rst)
        cmd_write |-> !status[6]);

    // R9: the cycle after reset shows no inhibit window
    p_reset_r9: assert property (@(posedge clk)
        rst |=> !window_open);

endmodule

// File: tb/tb_fhs_status_unit.sv
module tb_fhs_status_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 18;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        drum_mode = 1'b0;
    logic        cmd_write = 1'b0;
    logic [9:0]  cmd_track = '0;
    logic        prot_switch = 1'b0;
    logic [3:0]  prot_code = '0;
    logic        attached = 1'b0;
    logic        busy = 1'b0;
    logic [6:0]  next_sector = '0;
    logic        sector_phase = 1'b0;
    logic        cw_strobe = 1'b0;
    logic        word_tick = 1'b0;
    logic        xfer_start = 1'b0;
    logic        coinc_set = 1'b0;
    logic        abort_set = 1'b0;
    logic        write_done = 1'b0;
    logic [15:0] status;
    logic        wr_enable;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fhs_status_unit dut (
        .clk(clk), .rst(rst), .drum_mode(drum_mode), .cmd_write(cmd_write),
        .cmd_track(cmd_track), .prot_switch(prot_switch), .prot_code(prot_code),
        .attached(attached), .busy(busy), .next_sector(next_sector),
        .sector_phase(sector_phase), .cw_strobe(cw_strobe), .word_tick(word_tick),
        .xfer_start(xfer_start), .coinc_set(coinc_set), .abort_set(abort_set),
        .write_done(write_done), .status(status), .wr_enable(wr_enable)
    );

    // {drum, switch, code, track, expected write enable}
    localparam logic [16:0] VEC [0:NV-1] = '{
        {1'b0, 1'b0, 4'd7,  10'd0,   1'b1},
        {1'b0, 1'b1, 4'd0,  10'd0,   1'b0},
        {1'b0, 1'b1, 4'd0,  10'd1,   1'b1},
        {1'b0, 1'b1, 4'd3,  10'd7,   1'b0},
        {1'b0, 1'b1, 4'd3,  10'd8,   1'b1},
        {1'b0, 1'b1, 4'd7,  10'd127, 1'b0},
        {1'b0, 1'b1, 4'd6,  10'd64,  1'b1},
        {1'b0, 1'b1, 4'd9,  10'd127, 1'b0},
        {1'b0, 1'b1, 4'd2,  10'd129, 1'b0},
        {1'b0, 1'b1, 4'd2,  10'd132, 1'b1},
        {1'b1, 1'b1, 4'd2,  10'd129, 1'b1},
        {1'b1, 1'b1, 4'd10, 10'd767, 1'b0},
        {1'b1, 1'b1, 4'd10, 10'd768, 1'b1},
        {1'b1, 1'b1, 4'd9,  10'd511, 1'b0},
        {1'b1, 1'b1, 4'd9,  10'd512, 1'b1},
        {1'b1, 1'b1, 4'd15, 10'd767, 1'b0},
        {1'b1, 1'b1, 4'd8,  10'd200, 1'b0},
        {1'b1, 1'b0, 4'd10, 10'd5,   1'b1}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic bit6(input string req, input logic exp);
        #1;
        chk(req, {15'd0, status[6]}, {15'd0, exp});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(); step();
        rst = 1'b0;
        #1;
        chk("R9 reset status", status, 16'h0004);

        // R1 R2 R3: protection table
        attached = 1'b1;
        cmd_write = 1'b1;
        for (int i = 0; i < NV; i++) begin
            drum_mode   = VEC[i][16];
            prot_switch = VEC[i][15];
            prot_code   = VEC[i][14:11];
            cmd_track   = VEC[i][10:1];
            #1;
            chk($sformatf("R1 R2 R3 vector %0d wr_enable", i), {15'd0, wr_enable}, {15'd0, VEC[i][0]});
            chk($sformatf("R1 vector %0d status bit2", i), {15'd0, status[2]}, {15'd0, VEC[i][0]});
        end

        // R4 R5: layout and attach gating
        drum_mode = 1'b0; prot_switch = 1'b0;
        busy = 1'b1; next_sector = 7'h55; sector_phase = 1'b1;
        #1;
        chk("R4 R5 attached layout", status, 16'hD585);
        attached = 1'b0;
        #1;
        chk("R5 detached gating", status, 16'h0004);

        // R7: sticky sets
        coinc_set = 1'b1; abort_set = 1'b1; write_done = 1'b1;
        step();
        coinc_set = 1'b0; abort_set = 1'b0; write_done = 1'b0;
        step();
        chk("R7 sticky set disk", status, 16'h002E);

        // R8: clear, and same-cycle set wins
        xfer_start = 1'b1;
        step();
        chk("R8 clear", status, 16'h0004);
        coinc_set = 1'b1;
        step();
        xfer_start = 1'b0; coinc_set = 1'b0;
        step();
        chk("R8 set wins over clear", status, 16'h0024);
        xfer_start = 1'b1;
        step();
        xfer_start = 1'b0;

        // R7: drum write_done does not set parity
        drum_mode = 1'b1; write_done = 1'b1;
        step();
        write_done = 1'b0; drum_mode = 1'b0;
        step();
        chk("R7 drum no parity", status, 16'h0004);

        // R6: read-inhibit window
        attached = 1'b1; cmd_write = 1'b0; busy = 1'b0;
        bit6("R6 idle", 1'b0);
        cw_strobe = 1'b1;
        step();
        cw_strobe = 1'b0;
        bit6("R6 opens after strobe", 1'b1);
        word_tick = 1'b1;
        repeat (63) step();
        bit6("R6 open after 63 ticks", 1'b1);
        step();
        bit6("R6 closed after 64 ticks", 1'b0);
        word_tick = 1'b0;

        cmd_write = 1'b1; cw_strobe = 1'b1;
        step();
        cw_strobe = 1'b0;
        bit6("R6 write command hides inhibit", 1'b0);
        cmd_write = 1'b0;
        bit6("R6 window running for read", 1'b1);
        attached = 1'b0;
        bit6("R5 inhibit gated when detached", 1'b0);
        attached = 1'b1;

        word_tick = 1'b1;
        repeat (40) step();
        cw_strobe = 1'b1;
        step();
        cw_strobe = 1'b0;
        repeat (63) step();
        bit6("R6 restart reloads window", 1'b1);
        step();
        bit6("R6 restarted window ends", 1'b0);
        word_tick = 1'b0;

        drum_mode = 1'b1; cw_strobe = 1'b1;
        step();
        cw_strobe = 1'b0;
        bit6("R6 drum strobe ignored", 1'b0);
        drum_mode = 1'b0;

        // R9: reset closes an open window
        cw_strobe = 1'b1;
        step();
        cw_strobe = 1'b0;
        bit6("R6 open before reset", 1'b1);
        rst = 1'b1;
        step();
        rst = 1'b0;
        bit6("R9 reset closes window", 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule